// File: doc/BRIEF.md
# Strip Detector Hit Extraction Pipeline

This block takes one frame of digitised strip-detector samples per bunch-crossing clock and turns it into a sparse list of hits. Each channel carries a 6-bit unsigned ADC code. The block first removes that channel's programmable pedestal. It then averages the pedestal-corrected values of the whole frame to get the common-mode level, and subtracts that level from every channel of the same frame. Last, it compares each result with that channel's programmable threshold and keeps only the channels above it.

The surviving channels leave on a valid/ready stream, one word per accepted transfer. Each word carries a channel address and the corrected value, and a flag marks the last word of the frame. A frame with no survivors still produces one closing word, flagged as carrying no hit. The block holds a single frame in flight. A frame that arrives while the previous one is still draining is discarded and reported with a one-cycle pulse.

Pedestals and thresholds are loaded through two independent write ports, each taking a channel address and data.

Top module: `strip_hit_pipe`

## Requirements
- R1: While reset is asserted and after it is released, `hit_valid` and `frame_dropped` are 0, and every pedestal and threshold register holds 0.
- R2: The pedestal for channel c is a 6-bit unsigned value written by `ped_we` with `ped_addr`=c. The corrected value is the raw sample minus the pedestal. A frame captured on the same edge as a pedestal write uses the old pedestal, and later frames use the new one.
- R3: The common mode is floor(sum of the pedestal-corrected values / NCH), rounding toward minus infinity. It is subtracted from every channel of the same frame. The result is an 8-bit two's-complement value that saturates at -128 and +127.
- R4: A channel is emitted only when its corrected value is strictly greater than its threshold. The threshold is an 8-bit two's-complement value written by `thr_we` with `thr_addr`. A value equal to the threshold is suppressed.
- R5: Surviving channels are emitted one per handshake (`hit_valid` and `hit_ready` both 1), in strictly ascending channel address. `hit_eof`=1 only on the final word. `hit_valid` is 0 in the cycle after the final word is accepted.
- R6: A frame with no surviving channel emits exactly one word, with `hit_eof`=1, `hit_nohit`=1, `hit_addr`=0 and `hit_value`=0. On every other word `hit_nohit` is 0.
- R7: While `hit_valid`=1 and `hit_ready`=0, the output word (address, value, end flag, no-hit flag) stays unchanged on the next cycle.
- R8: A frame presented while `hit_valid`=1 is discarded. `frame_dropped` is 1 for exactly the cycle after that edge, and the frame being emitted continues unchanged. Otherwise `frame_dropped` is 0.
- R9: A frame presented while `hit_valid`=0 is captured on that edge, and its first word is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | A new frame of samples is present |
| frame_samples | input | NCH*ADC_W | Raw codes; channel c at bits [c*ADC_W +: ADC_W] |
| ped_we | input | 1 | Pedestal write strobe |
| ped_addr | input | AW | Channel written by the pedestal port |
| ped_data | input | ADC_W | Pedestal value (unsigned) |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | AW | Channel written by the threshold port |
| thr_data | input | VAL_W | Threshold value (two's complement) |
| hit_valid | output | 1 | Output word present |
| hit_ready | input | 1 | Downstream accepts the word |
| hit_addr | output | AW | Channel address of the hit |
| hit_value | output | VAL_W | Corrected value (two's complement) |
| hit_eof | output | 1 | Last word of the frame |
| hit_nohit | output | 1 | Closing word of a frame with no survivors |
| frame_dropped | output | 1 | A frame was discarded on the previous edge |

## Verification
The threshold property compares each emitted value with the threshold register currently indexed by `hit_addr`. It therefore assumes thresholds are not rewritten while a frame is draining. The bench loads thresholds and pedestals only while `hit_valid` is low. Apart from that, no assumption is made on `hit_ready` or on when `frame_valid` arrives. The stimulus deliberately stalls the stream and presents a frame in the middle of a drain.

// File: rtl/shp_pkg.sv
package shp_pkg;

  // Output scanner state: idle waits for a frame, busy drains one frame.
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_BUSY = 1'b1
  } scan_state_e;

endpackage

// File: rtl/shp_cfg_regs.sv
// Bank of per-channel configuration registers with a single write port.
module shp_cfg_regs #(
  parameter int NCH = 128,
  parameter int AW  = 7,
  parameter int DW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] q_flat
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          sel;
    logic [DW-1:0] val_q;

    assign sel = wr_en && (wr_addr == AW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (sel) begin
        val_q <= wr_data;
      end
    end

    assign q_flat[c*DW +: DW] = val_q;
  end

endmodule

// File: rtl/shp_cm_corrector.sv
// Pedestal removal, frame-mean common-mode removal and saturation (combinational).
module shp_cm_corrector #(
  parameter int NCH   = 128,
  parameter int ADC_W = 6,
  parameter int VAL_W = 8
) (
  input  logic [NCH*ADC_W-1:0] raw_flat,
  input  logic [NCH*ADC_W-1:0] ped_flat,
  output logic [NCH*VAL_W-1:0] cor_flat
);

  localparam int LOG2N = $clog2(NCH);
  localparam int DW    = ADC_W + 1;        // pedestal difference width
  localparam int SW    = DW + LOG2N;       // frame sum width
  localparam int XW    = SW + VAL_W;       // headroom before saturation
  localparam logic signed [XW-1:0] SAT_HI = XW'((2 ** (VAL_W - 1)) - 1);
  localparam logic signed [XW-1:0] SAT_LO = XW'(-(2 ** (VAL_W - 1)));

  logic signed [DW-1:0] diff [NCH];
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] mean;

  for (genvar c = 0; c < NCH; c++) begin : g_diff
    assign diff[c] = $signed({1'b0, raw_flat[c*ADC_W +: ADC_W]})
                   - $signed({1'b0, ped_flat[c*ADC_W +: ADC_W]});
  end

  always_comb begin
    sum = '0;
    for (int c = 0; c < NCH; c++) begin
      sum = sum + SW'(diff[c]);
    end
  end

  // Arithmetic shift: division by a power of two rounding toward minus infinity.
  assign mean = sum >>> LOG2N;

  for (genvar c = 0; c < NCH; c++) begin : g_cor
    logic signed [XW-1:0]    wide;
    logic        [VAL_W-1:0] sat;

    assign wide = XW'(diff[c]) - XW'(mean);

    always_comb begin
      if (wide > SAT_HI) begin
        sat = SAT_HI[VAL_W-1:0];
      end else if (wide < SAT_LO) begin
        sat = SAT_LO[VAL_W-1:0];
      end else begin
        sat = wide[VAL_W-1:0];
      end
    end

    assign cor_flat[c*VAL_W +: VAL_W] = sat;
  end

endmodule

// File: rtl/shp_hit_scanner.sv
// Holds one corrected frame and its keep mask; emits survivors lowest channel first.
module shp_hit_scanner
  import shp_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int VAL_W = 8,
  parameter int AW    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NCH*VAL_W-1:0] cor_flat,
  input  logic [NCH*VAL_W-1:0] thr_flat,
  input  logic                 out_ready,
  output logic                 busy,
  output logic                 out_valid,
  output logic [AW-1:0]        out_addr,
  output logic [VAL_W-1:0]     out_value,
  output logic                 out_last,
  output logic                 out_none
);

  scan_state_e            state_q, state_d;
  logic [NCH-1:0]         keep;
  logic [NCH-1:0]         pend_q, pend_d;
  logic [NCH-1:0]         first_oh;
  logic [NCH-1:0]         rest;
  logic [NCH*VAL_W-1:0]   frame_q;
  logic                   frame_en;

  for (genvar c = 0; c < NCH; c++) begin : g_keep
    assign keep[c] = $signed(cor_flat[c*VAL_W +: VAL_W])
                   > $signed(thr_flat[c*VAL_W +: VAL_W]);
  end

  // Lowest pending channel as a one-hot vector, and what remains after it.
  assign first_oh = pend_q & (~pend_q + NCH'(1));
  assign rest     = pend_q & ~first_oh;

  assign busy      = (state_q == SCAN_BUSY);
  assign out_valid = busy;
  assign out_last  = busy && (rest == '0);
  assign out_none  = busy && (pend_q == '0);

  always_comb begin
    out_addr  = '0;
    out_value = '0;
    for (int c = 0; c < NCH; c++) begin
      if (first_oh[c]) begin
        out_addr  = AW'(c);
        out_value = frame_q[c*VAL_W +: VAL_W];
      end
    end
  end

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    frame_en = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (load) begin
          state_d  = SCAN_BUSY;
          pend_d   = keep;
          frame_en = 1'b1;
        end
      end
      SCAN_BUSY: begin
        if (out_ready) begin
          pend_d = rest;
          if (out_last) begin
            state_d = SCAN_IDLE;
          end
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_en) begin
      frame_q <= cor_flat;
    end
  end

endmodule

// File: rtl/strip_hit_pipe.sv
// Top: configuration registers, frame correction and sparse hit output.
module strip_hit_pipe #(
  parameter  int NCH   = 128,
  parameter  int ADC_W = 6,
  parameter  int VAL_W = 8,
  localparam int AW    = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic [NCH*ADC_W-1:0] frame_samples,
  input  logic                 ped_we,
  input  logic [AW-1:0]        ped_addr,
  input  logic [ADC_W-1:0]     ped_data,
  input  logic                 thr_we,
  input  logic [AW-1:0]        thr_addr,
  input  logic [VAL_W-1:0]     thr_data,
  output logic                 hit_valid,
  input  logic                 hit_ready,
  output logic [AW-1:0]        hit_addr,
  output logic [VAL_W-1:0]     hit_value,
  output logic                 hit_eof,
  output logic                 hit_nohit,
  output logic                 frame_dropped
);

  logic [NCH*ADC_W-1:0] ped_flat;
  logic [NCH*VAL_W-1:0] thr_flat;
  logic [NCH*VAL_W-1:0] cor_flat;
  logic                 busy;
  logic                 accept;
  logic                 drop_d, drop_q;

  shp_cfg_regs #(.NCH(NCH), .AW(AW), .DW(ADC_W)) u_ped (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ped_we),
    .wr_addr (ped_addr),
    .wr_data (ped_data),
    .q_flat  (ped_flat)
  );

  shp_cfg_regs #(.NCH(NCH), .AW(AW), .DW(VAL_W)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (thr_we),
    .wr_addr (thr_addr),
    .wr_data (thr_data),
    .q_flat  (thr_flat)
  );

  shp_cm_corrector #(.NCH(NCH), .ADC_W(ADC_W), .VAL_W(VAL_W)) u_cor (
    .raw_flat (frame_samples),
    .ped_flat (ped_flat),
    .cor_flat (cor_flat)
  );

  assign accept = frame_valid && !busy;
  assign drop_d = frame_valid && busy;

  shp_hit_scanner #(.NCH(NCH), .VAL_W(VAL_W), .AW(AW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cor_flat  (cor_flat),
    .thr_flat  (thr_flat),
    .out_ready (hit_ready),
    .busy      (busy),
    .out_valid (hit_valid),
    .out_addr  (hit_addr),
    .out_value (hit_value),
    .out_last  (hit_eof),
    .out_none  (hit_nohit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
    end else begin
      drop_q <= drop_d;
    end
  end

  assign frame_dropped = drop_q;

endmodule

// File: rtl/strip_hit_pipe_chk.sv
// Protocol and ordering properties, attached to every strip_hit_pipe instance.
module strip_hit_pipe_chk #(
  parameter int NCH   = 128,
  parameter int VAL_W = 8,
  parameter int AW    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_valid,
  input logic                 hit_valid,
  input logic                 hit_ready,
  input logic [AW-1:0]        hit_addr,
  input logic [VAL_W-1:0]     hit_value,
  input logic                 hit_eof,
  input logic                 hit_nohit,
  input logic                 frame_dropped,
  input logic [NCH*VAL_W-1:0] thr_flat
);

  logic [VAL_W-1:0] thr_sel;
  assign thr_sel = thr_flat[hit_addr*VAL_W +: VAL_W];

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!hit_valid && !frame_dropped));

  a_r4_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_nohit) |-> ($signed(hit_value) > $signed(thr_sel)));

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready && !hit_eof) |=> (hit_valid && (hit_addr > $past(hit_addr))));

  a_r5_ends_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready && hit_eof) |=> !hit_valid);

  a_r6_nohit_word: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_nohit) |-> (hit_eof && (hit_addr == '0) && (hit_value == '0)));

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_addr) && $stable(hit_value)
                                   && $stable(hit_eof) && $stable(hit_nohit)));

  a_r8_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && hit_valid) |=> frame_dropped);

  a_r8_no_false_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && hit_valid) |=> !frame_dropped);

  a_r9_capture_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !hit_valid) |=> hit_valid);

endmodule

bind strip_hit_pipe strip_hit_pipe_chk #(.NCH(NCH), .VAL_W(VAL_W), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_valid   (frame_valid),
  .hit_valid     (hit_valid),
  .hit_ready     (hit_ready),
  .hit_addr      (hit_addr),
  .hit_value     (hit_value),
  .hit_eof       (hit_eof),
  .hit_nohit     (hit_nohit),
  .frame_dropped (frame_dropped),
  .thr_flat      (thr_flat)
);

// File: tb/tb_strip_hit_pipe.sv
module tb_strip_hit_pipe;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH   = 128;
  localparam int ADC_W = 6;
  localparam int VAL_W = 8;
  localparam int AW    = 7;

  logic                 clk;
  logic                 rst_n;
  logic                 frame_valid;
  logic [NCH*ADC_W-1:0] frame_samples;
  logic                 ped_we;
  logic [AW-1:0]        ped_addr;
  logic [ADC_W-1:0]     ped_data;
  logic                 thr_we;
  logic [AW-1:0]        thr_addr;
  logic [VAL_W-1:0]     thr_data;
  logic                 hit_valid;
  logic                 hit_ready;
  logic [AW-1:0]        hit_addr;
  logic [VAL_W-1:0]     hit_value;
  logic                 hit_eof;
  logic                 hit_nohit;
  logic                 frame_dropped;

  strip_hit_pipe #(.NCH(NCH), .ADC_W(ADC_W), .VAL_W(VAL_W)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  int samp  [NCH];
  int ped_m [NCH];
  int thr_m [NCH];
  int exp_a [NCH];
  int exp_v [NCH];
  int exp_n;
  int got_a [NCH+1];
  int got_v [NCH+1];
  bit got_e [NCH+1];
  bit got_z [NCH+1];
  int got_n;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=%0d expected<=%0d cycles", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [NCH*ADC_W-1:0] pack_samples();
    logic [NCH*ADC_W-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*ADC_W +: ADC_W] = ADC_W'(samp[c]);
    return v;
  endfunction

  // Reference computation from the stated arithmetic.
  task automatic build_expect();
    int d [NCH];
    int s;
    int m;
    int v;
    s = 0;
    for (int c = 0; c < NCH; c++) begin
      d[c] = samp[c] - ped_m[c];
      s += d[c];
    end
    if (s >= 0) m = s / NCH;
    else m = -((-s + NCH - 1) / NCH);
    exp_n = 0;
    for (int c = 0; c < NCH; c++) begin
      v = d[c] - m;
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      if (v > thr_m[c]) begin
        exp_a[exp_n] = c;
        exp_v[exp_n] = v;
        exp_n++;
      end
    end
  endtask

  task automatic write_all_thr(input int v);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      thr_we = 1'b1; thr_addr = AW'(c); thr_data = VAL_W'(v); thr_m[c] = v;
    end
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic write_thr(input int c, input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_addr = AW'(c); thr_data = VAL_W'(v); thr_m[c] = v;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic write_all_ped(input int v);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      ped_we = 1'b1; ped_addr = AW'(c); ped_data = ADC_W'(v); ped_m[c] = v;
    end
    @(negedge clk); ped_we = 1'b0;
  endtask

  task automatic write_ped(input int c, input int v);
    @(negedge clk);
    ped_we = 1'b1; ped_addr = AW'(c); ped_data = ADC_W'(v); ped_m[c] = v;
    @(negedge clk); ped_we = 1'b0;
  endtask

  // Presents the frame in samp for one cycle; returns at the following negedge.
  task automatic drive_frame();
    @(negedge clk);
    frame_valid = 1'b1; frame_samples = pack_samples();
    @(negedge clk);
    frame_valid = 1'b0;
    chk(hit_valid == 1'b1, "R9", "first word valid after capture", int'(hit_valid), 1);
  endtask

  // Drains one frame; ready follows stall_mod (0 = always ready).
  task automatic collect(input int stall_mod);
    bit done = 0;
    bit was_stalled = 0;
    int cyc = 0;
    int pa = 0, pv = 0;
    bit pe = 0, pz = 0;
    got_n = 0;
    while (!done && cyc < 4 * NCH + 20) begin
      hit_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      if (was_stalled) begin
        chk(hit_valid && int'(hit_addr) == pa && int'($signed(hit_value)) == pv
            && hit_eof == pe && hit_nohit == pz, "R7", "stalled word changed",
            int'(hit_addr), pa);
      end
      if (hit_valid && hit_ready && got_n <= NCH) begin
        got_a[got_n] = int'(hit_addr);
        got_v[got_n] = int'($signed(hit_value));
        got_e[got_n] = hit_eof;
        got_z[got_n] = hit_nohit;
        got_n++;
        if (hit_eof) done = 1;
      end
      was_stalled = hit_valid && !hit_ready;
      pa = int'(hit_addr); pv = int'($signed(hit_value)); pe = hit_eof; pz = hit_nohit;
      cyc++;
      @(negedge clk);
    end
    hit_ready = 1'b1;
    chk(done, "R5", "frame ended with eof word", int'(done), 1);
    chk(hit_valid == 1'b0, "R5", "valid low after eof accepted", int'(hit_valid), 0);
  endtask

  task automatic compare(input string req);
    if (exp_n == 0) begin
      chk(got_n == 1, "R6", "empty frame word count", got_n, 1);
      if (got_n >= 1) begin
        chk(got_e[0] && got_z[0], "R6", "empty word flags eof&nohit", int'(got_e[0] && got_z[0]), 1);
        chk(got_a[0] == 0 && got_v[0] == 0, "R6", "empty word addr/value", got_a[0] + got_v[0], 0);
      end
    end else begin
      chk(got_n == exp_n, req, "hit count", got_n, exp_n);
      for (int i = 0; i < got_n && i < exp_n; i++) begin
        if (got_a[i] != exp_a[i]) chk(0, req, $sformatf("word %0d address", i), got_a[i], exp_a[i]);
        if (got_v[i] != exp_v[i]) chk(0, req, $sformatf("word %0d value", i), got_v[i], exp_v[i]);
        if (got_e[i] != (i == exp_n - 1)) chk(0, "R5", $sformatf("word %0d eof", i), int'(got_e[i]), int'(i == exp_n - 1));
        if (got_z[i]) chk(0, "R6", $sformatf("word %0d nohit", i), 1, 0);
      end
      checks++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hit_valid == 1'b0, "R1", "valid during reset", int'(hit_valid), 0);
    chk(frame_dropped == 1'b0, "R1", "drop during reset", int'(frame_dropped), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(hit_valid == 1'b0 && frame_dropped == 1'b0, "R1", "outputs idle after reset",
        int'(hit_valid) + int'(frame_dropped), 0);
    for (int c = 0; c < NCH; c++) begin ped_m[c] = 0; thr_m[c] = 0; end
  endtask

  task automatic t_reset_regs();
    // Zero pedestals and thresholds after reset: output follows raw minus mean.
    for (int c = 0; c < NCH; c++) samp[c] = (c * 5) % 64;
    build_expect();
    drive_frame();
    collect(0);
    compare("R1");
  endtask

  task automatic t_pedestal();
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      ped_we = 1'b1; ped_addr = AW'(c); ped_data = ADC_W'((c * 7) % 64); ped_m[c] = (c * 7) % 64;
    end
    @(negedge clk); ped_we = 1'b0;
    write_all_thr(2);
    for (int c = 0; c < NCH; c++) samp[c] = (c * 13 + 5) % 64;
    build_expect();
    drive_frame();
    collect(0);
    compare("R2");
    compare("R3");
  endtask

  task automatic t_threshold();
    write_all_ped(0);
    write_all_thr(0);
    write_thr(3, 5);
    write_thr(9, 3);
    for (int c = 0; c < NCH; c++) samp[c] = 20;
    samp[3] = 25;
    samp[9] = 24;
    drive_frame();
    collect(0);
    chk(got_n == 1, "R4", "equal-to-threshold suppressed, count", got_n, 1);
    chk(got_a[0] == 9 && got_v[0] == 4, "R4", "surviving channel 9 value 4", got_a[0] * 256 + got_v[0], 9 * 256 + 4);
  endtask

  task automatic t_empty();
    write_all_thr(0);
    for (int c = 0; c < NCH; c++) samp[c] = 33;
    build_expect();
    drive_frame();
    collect(0);
    compare("R6");
  endtask

  task automatic t_floor();
    // Sum -1 over all channels: mean must be -1, not 0.
    for (int c = 0; c < NCH; c++) samp[c] = 10;
    write_all_ped(10);
    write_ped(0, 11);
    build_expect();
    drive_frame();
    collect(0);
    chk(got_n == NCH - 1, "R3", "floor mean gives 127 hits", got_n, NCH - 1);
    chk(got_a[0] == 1 && got_v[0] == 1, "R3", "first hit channel 1 value 1", got_a[0] * 256 + got_v[0], 256 + 1);
    compare("R3");
  endtask

  task automatic t_stall();
    write_all_ped(4);
    write_all_thr(-3);
    for (int c = 0; c < NCH; c++) samp[c] = (c * c + 3 * c) % 64;
    build_expect();
    hit_ready = 1'b0;
    drive_frame();
    collect(3);
    compare("R5");
  endtask

  task automatic t_drop();
    logic [NCH*ADC_W-1:0] other;
    write_all_ped(0);
    write_all_thr(0);
    for (int c = 0; c < NCH; c++) samp[c] = (c % 4 == 0) ? 40 : 20;
    build_expect();
    for (int c = 0; c < NCH; c++) other[c*ADC_W +: ADC_W] = ADC_W'(63 - (c % 64));
    hit_ready = 1'b0;
    drive_frame();
    frame_valid = 1'b1; frame_samples = other;
    @(negedge clk);
    frame_valid = 1'b0;
    chk(frame_dropped == 1'b1, "R8", "drop pulse after busy frame", int'(frame_dropped), 1);
    @(negedge clk);
    chk(frame_dropped == 1'b0, "R8", "drop pulse lasts one cycle", int'(frame_dropped), 0);
    chk(int'(hit_addr) == exp_a[0], "R8", "held frame still first word", int'(hit_addr), exp_a[0]);
    collect(0);
    compare("R8");
    chk(frame_dropped == 1'b0, "R8", "no drop when idle", int'(frame_dropped), 0);
  endtask

  task automatic t_same_cycle_write();
    write_all_ped(0);
    write_all_thr(0);
    for (int c = 0; c < NCH; c++) samp[c] = 30;
    build_expect();   // uses old pedestal 0 on channel 5
    @(negedge clk);
    frame_valid = 1'b1; frame_samples = pack_samples();
    ped_we = 1'b1; ped_addr = AW'(5); ped_data = ADC_W'(40);
    @(negedge clk);
    frame_valid = 1'b0; ped_we = 1'b0;
    collect(0);
    compare("R2");
    ped_m[5] = 40;
    build_expect();   // new pedestal applies to the next frame
    drive_frame();
    collect(0);
    chk(got_n == NCH - 1, "R2", "new pedestal used next frame", got_n, NCH - 1);
    compare("R2");
  endtask

  initial begin
    frame_valid = 1'b0; frame_samples = '0;
    ped_we = 1'b0; ped_addr = '0; ped_data = '0;
    thr_we = 1'b0; thr_addr = '0; thr_data = '0;
    hit_ready = 1'b1;
    rst_n = 1'b0;
    t_reset();
    t_reset_regs();
    t_pedestal();
    t_threshold();
    t_empty();
    t_floor();
    t_stall();
    t_drop();
    t_same_cycle_write();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule